// File: doc/BRIEF.md
# Sleep-Mode Entry and Exit Controller

This block sequences a synchronous SRAM into and out of a low-power snooze state. An asynchronous, active-high sleep request is first brought into the clock domain. A small state machine then steps through four states: active, entering, asleep and exiting. Entry and exit each last a fixed number of clocks, two by default. From the first entry cycle until exit has finished, the block raises an input-gate signal and a high-impedance command. The address, strobe and write logic use the gate to ignore every external input, and the data I/O drivers use the high-impedance command, so the array contents are left untouched.

The block also checks how the surrounding system uses it. It raises a sticky violation flag in two cases. The first is any chip enable or address strobe going active during the exit window. The second is a request that arrives while a burst is still selected. Reset returns the block to the active state with every output low.

Top module: `sleep_ctrl`

## Requirements
- R1: After reset, and at once while rst_ni is low, sleep_o, gate_o, hiz_o and viol_o are 0.
- R2: The request passes through two synchronizer flops. gate_o and hiz_o rise after the third consecutive rising edge at which sleep_req_i is high.
- R3: Entry lasts ENTRY_CYC (default 2) clocks. sleep_o rises two edges after gate_o rises.
- R4: sleep_o falls after the third consecutive rising edge at which sleep_req_i is low. gate_o and hiz_o then stay high for EXIT_CYC (default 2) more edges before they fall.
- R5: Once entry has started it runs to completion even if the request drops. The block is then asleep for one cycle and exits normally.
- R6: In the entering, asleep and exiting states, gate_o and hiz_o are both 1. sleep_o is 1 only in the asleep state.
- R7: Strobe, chip-enable and burst activity during entry or sleep neither sets viol_o nor changes the sequence.
- R8: Any of these during an exit cycle sets viol_o at the next edge: cpu_stb_n_i low, ctl_stb_n_i low, sel1_n_i low, sel2_i high, or sel3_n_i low.
- R9: If burst_sel_i is high at the edge where the synchronized request is first seen in the active state, viol_o is set. Entry still proceeds.
- R10: viol_o stays 1 until reset.
- R11: Strobe, enable and burst activity in the active state with no request pending, including after exit has finished, does not set viol_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sleep_req_i | input | 1 | Asynchronous sleep request, active high |
| cpu_stb_n_i | input | 1 | Processor address strobe, active low |
| ctl_stb_n_i | input | 1 | Controller address strobe, active low |
| sel1_n_i | input | 1 | Chip enable 1, active low |
| sel2_i | input | 1 | Chip enable 2, active high |
| sel3_n_i | input | 1 | Chip enable 3, active low |
| burst_sel_i | input | 1 | A burst is currently selected |
| sleep_o | output | 1 | Device is asleep |
| gate_o | output | 1 | Block all other inputs |
| hiz_o | output | 1 | Force data I/Os to high impedance |
| viol_o | output | 1 | Sticky protocol-violation flag |

## Verification
A cycle-by-cycle sequence runs three cases: a long request that enters, sleeps and exits; a one-cycle request pulse that must still complete entry; and a request held high through sleep. Together these separate synchronizer latency from entry and exit length. During that sequence, enables and burst are driven in the entering, asleep and idle active states to confirm that these states tolerate them. Directed cases drive a single strobe or a single enable inside the exit window, and the same signals one cycle after exit ends. This shows that the window edges are exact. Further cases raise a request with a burst selected, and assert reset in the middle of sleep.

// File: rtl/sleep_pkg.sv
package sleep_pkg;
  typedef enum logic [1:0] {
    ST_ACTIVE = 2'd0,
    ST_ENTER  = 2'd1,
    ST_ASLEEP = 2'd2,
    ST_EXIT   = 2'd3
  } slp_state_e;
endpackage

// File: rtl/slp_sync.sv
module slp_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] ff_q;

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) ff_q[g] <= 1'b0;
        else         ff_q[g] <= d_i;
    end else begin : g_rest
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) ff_q[g] <= 1'b0;
        else         ff_q[g] <= ff_q[g-1];
    end
  end

  assign q_o = ff_q[STAGES-1];
endmodule

// File: rtl/slp_fsm.sv
module slp_fsm
  import sleep_pkg::*;
#(
  parameter int ENTRY_CYC = 2,
  parameter int EXIT_CYC  = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       req_s_i,
  output slp_state_e state_o
);
  localparam int MAXC = (ENTRY_CYC > EXIT_CYC) ? ENTRY_CYC : EXIT_CYC;
  localparam int CW   = (MAXC < 2) ? 1 : $clog2(MAXC + 1);

  slp_state_e state_q, state_d;
  logic [CW-1:0] cnt_q;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_ACTIVE: if (req_s_i) state_d = ST_ENTER;
      ST_ENTER:  if (cnt_q == CW'(ENTRY_CYC - 1)) state_d = ST_ASLEEP;
      ST_ASLEEP: if (!req_s_i) state_d = ST_EXIT;
      ST_EXIT:   if (cnt_q == CW'(EXIT_CYC - 1)) state_d = ST_ACTIVE;
      default:   state_d = ST_ACTIVE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_ACTIVE;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      if (state_d != state_q) cnt_q <= '0;
      else if (state_q == ST_ENTER || state_q == ST_EXIT) cnt_q <= cnt_q + 1'b1;
    end
  end

  assign state_o = state_q;

  // R2: no request, no departure from active
  p_idle_holds_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_ACTIVE && !req_s_i) |=> state_q == ST_ACTIVE);
  // R5: entry never aborts
  p_entry_completes_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_ENTER) |=> (state_q == ST_ENTER || state_q == ST_ASLEEP));
  // R4: exit only back to active
  p_exit_to_active_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_EXIT) |=> (state_q == ST_EXIT || state_q == ST_ACTIVE));
endmodule

// File: rtl/slp_guard.sv
module slp_guard
  import sleep_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  slp_state_e state_i,
  input  logic       req_s_i,
  input  logic       cpu_stb_n_i,
  input  logic       ctl_stb_n_i,
  input  logic       sel1_n_i,
  input  logic       sel2_i,
  input  logic       sel3_n_i,
  input  logic       burst_sel_i,
  output logic       viol_o
);
  logic any_en, recov_bad, burst_bad, viol_q;

  assign any_en    = !cpu_stb_n_i || !ctl_stb_n_i || !sel1_n_i || sel2_i || !sel3_n_i;
  assign recov_bad = (state_i == ST_EXIT) && any_en;
  assign burst_bad = (state_i == ST_ACTIVE) && req_s_i && burst_sel_i;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)                     viol_q <= 1'b0;
    else if (recov_bad || burst_bad) viol_q <= 1'b1;

  assign viol_o = viol_q;

  p_sticky_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    viol_q |=> viol_q);
  // R11: idle activity never flags
  p_idle_no_flag_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i == ST_ACTIVE && !req_s_i) |=> $stable(viol_q));
  // R7: activity while entering or asleep never flags
  p_sleep_no_flag_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i == ST_ENTER || state_i == ST_ASLEEP) |=> $stable(viol_q));
endmodule

// File: rtl/sleep_ctrl.sv
module sleep_ctrl
  import sleep_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int ENTRY_CYC   = 2,
  parameter int EXIT_CYC    = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sleep_req_i,
  input  logic cpu_stb_n_i,
  input  logic ctl_stb_n_i,
  input  logic sel1_n_i,
  input  logic sel2_i,
  input  logic sel3_n_i,
  input  logic burst_sel_i,
  output logic sleep_o,
  output logic gate_o,
  output logic hiz_o,
  output logic viol_o
);
  logic       req_s;
  slp_state_e state;

  slp_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(sleep_req_i), .q_o(req_s)
  );

  slp_fsm #(.ENTRY_CYC(ENTRY_CYC), .EXIT_CYC(EXIT_CYC)) u_fsm (
    .clk_i(clk_i), .rst_ni(rst_ni), .req_s_i(req_s), .state_o(state)
  );

  slp_guard u_guard (
    .clk_i(clk_i), .rst_ni(rst_ni), .state_i(state), .req_s_i(req_s),
    .cpu_stb_n_i(cpu_stb_n_i), .ctl_stb_n_i(ctl_stb_n_i),
    .sel1_n_i(sel1_n_i), .sel2_i(sel2_i), .sel3_n_i(sel3_n_i),
    .burst_sel_i(burst_sel_i), .viol_o(viol_o)
  );

  assign sleep_o = (state == ST_ASLEEP);
  assign gate_o  = (state != ST_ACTIVE);
  assign hiz_o   = (state != ST_ACTIVE);

  p_sleep_gated_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sleep_o |-> (gate_o && hiz_o));
  p_gate_needs_req_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(gate_o) |-> $past(req_s));
  p_exit_tail_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(sleep_o) |-> gate_o);
  p_entry_len_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sleep_o) |-> $past(gate_o));
endmodule

// File: tb/sleep_ctrl_tb.sv
module sleep_ctrl_tb_top;
  logic clk = 1'b0, rst_ni = 1'b0;
  logic req = 1'b0, cpu_n = 1'b1, ctl_n = 1'b1, s1_n = 1'b1, s2 = 1'b0, s3_n = 1'b1, burst = 1'b0;
  logic sleep, gate, hiz, viol;
  int checks = 0, failures = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  sleep_ctrl dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .sleep_req_i(req),
    .cpu_stb_n_i(cpu_n), .ctl_stb_n_i(ctl_n), .sel1_n_i(s1_n),
    .sel2_i(s2), .sel3_n_i(s3_n), .burst_sel_i(burst),
    .sleep_o(sleep), .gate_o(gate), .hiz_o(hiz), .viol_o(viol)
  );

  // {req, en, burst, exp_sleep, exp_gate, exp_viol}; expectations after that edge
  localparam logic [5:0] VEC [20] = '{
    6'b100000, 6'b100000, 6'b100010, 6'b100010, 6'b100110,
    6'b111110, 6'b000110, 6'b000110, 6'b000010, 6'b000010,
    6'b000000, 6'b011000, 6'b100000, 6'b000000, 6'b000010,
    6'b010010, 6'b000110, 6'b000010, 6'b000010, 6'b000000
  };

  task automatic chk(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%b expected=%b", tag, act, exp);
    end
  endtask

  task automatic all_en(input logic on);
    cpu_n = !on; s1_n = !on; s2 = on; s3_n = !on;
  endtask

  task automatic do_reset;
    rst_ni = 1'b0; req = 1'b0; burst = 1'b0; all_en(1'b0); ctl_n = 1'b1;
    repeat (2) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
  endtask

  // sel: 0 ctl strobe, 1 sel2, 2 sel1; late=1 drives after exit ends
  task automatic recov_case(input int sel, input bit late);
    do_reset();
    req = 1'b1;
    repeat (6) @(negedge clk);
    chk("R3 asleep before release", sleep, 1'b1);
    req = 1'b0;
    repeat (late ? 5 : 3) @(negedge clk);
    if (!late) begin
      chk("R4 sleep low in exit", sleep, 1'b0);
      chk("R4 gate high in exit", gate, 1'b1);
    end
    if (sel == 0) ctl_n = 1'b0; else if (sel == 1) s2 = 1'b1; else s1_n = 1'b0;
    @(negedge clk);
    ctl_n = 1'b1; s2 = 1'b0; s1_n = 1'b1;
    if (late) chk("R11 no flag after exit", viol, 1'b0);
    else      chk("R8 recovery violation", viol, 1'b1);
    repeat (4) @(negedge clk);
    chk("R4 gate released", gate, 1'b0);
    if (!late) chk("R10 flag sticky", viol, 1'b1);
  endtask

  initial begin
    @(negedge clk);
    chk("R1 reset sleep", sleep, 1'b0);
    chk("R1 reset gate", gate, 1'b0);
    chk("R1 reset hiz", hiz, 1'b0);
    chk("R1 reset viol", viol, 1'b0);
    rst_ni = 1'b1;
    @(negedge clk);

    // R2 R3 R4 R5 R6 R7 R11 table walk
    for (int i = 0; i < 20; i++) begin
      req = VEC[i][5]; all_en(VEC[i][4]); burst = VEC[i][3];
      @(negedge clk);
      chk($sformatf("R2/R3 sleep vec%0d", i), sleep, VEC[i][2]);
      chk($sformatf("R6 gate vec%0d", i), gate, VEC[i][1]);
      chk($sformatf("R6 hiz vec%0d", i), hiz, VEC[i][1]);
      chk($sformatf("R7/R11 viol vec%0d", i), viol, VEC[i][0]);
    end
    all_en(1'b0); burst = 1'b0;

    recov_case(0, 1'b0);
    do_reset();
    chk("R10 reset clears flag", viol, 1'b0);
    recov_case(1, 1'b0);
    recov_case(2, 1'b0);
    recov_case(1, 1'b1);
    recov_case(0, 1'b1);

    // R9 burst still selected at request
    do_reset();
    burst = 1'b1; req = 1'b1;
    repeat (3) @(negedge clk);
    chk("R9 burst violation", viol, 1'b1);
    chk("R9 entry proceeds", gate, 1'b1);
    repeat (2) @(negedge clk);
    chk("R9 asleep after entry", sleep, 1'b1);

    // R1 reset mid-sleep
    burst = 1'b0;
    #3 rst_ni = 1'b0;
    #1;
    chk("R1 async reset sleep", sleep, 1'b0);
    chk("R1 async reset hiz", hiz, 1'b0);
    chk("R1 async reset viol", viol, 1'b0);
    req = 1'b0;
    @(negedge clk);
    rst_ni = 1'b1;

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule